// File: doc/BRIEF.md
# Slave Grid Shift Network

This block is the data-transfer fabric between one master core and a torus grid of slave cores. Every slave owns a single network register. A slave may load a value from its stack into that register, and the register's contents are always visible on a read port so that the slave can copy it back onto its stack. The master reaches only the register of slave 0: it can copy that register onto its own stack, or overwrite it with a value from its stack.

To reach any other slave, the master issues whole-grid shift commands. A left shift moves every register value one column toward column 0 within its row. A right shift moves values the other way. Both wrap around the row ends, and all registers change in the same clock cycle. After one left shift, slave 0 holds the value the second slave produced, so repeated shifts give the master each slave of row 0 in turn. Each slave also has constant outputs that give its own x and y position. The grid size and the data width are parameters. The processor cores are not part of this block, and the stack sides are plain valid/data ports.

Top module: `grid_net`

## Requirements
- R1: While rst_ni is low, and after it is released with no command applied, every network register reads zero.
- R2: When put_valid_i[s] is high at a rising edge, slave s's register holds put_data_i slice s (bits s*DW +: DW) from the next cycle on. Slave s is at column s % COLS and row s / COLS.
- R3: get_data_o slice s always shows slave s's register, and s2m_data_o always shows slave 0's register.
- R4: When m2s_valid_i is high at an edge, slave 0's register takes m2s_data_i. This overrides a put by slave 0 in the same cycle.
- R5: A left shift (shift_left_i high, shift_right_i low) loads each register at column x of row y with the old value at column (x+1) mod COLS of the same row. All registers move in the same cycle.
- R6: A right shift (shift_right_i high, shift_left_i low) loads each register at column x with the old value at column (x+COLS-1) mod COLS of the same row.
- R7: When both shift inputs are high in the same cycle, no shift takes place.
- R8: A shift and a write (put or M2S) in the same cycle: the shift is applied first and the written value then lands in the register of the writing slave. Every other register takes its shifted value.
- R9: coord_x_o slice s (XW bits) equals s % COLS and coord_y_o slice s (YW bits) equals s / COLS. XW and YW are the clog2 of COLS and ROWS, with a minimum of 1.
- R10: With no shift and no write, every register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| shift_left_i | input | 1 | Rotate all rows one column left |
| shift_right_i | input | 1 | Rotate all rows one column right |
| put_valid_i | input | N | Per-slave write strobe |
| put_data_i | input | N*DW | Per-slave write data |
| get_data_o | output | N*DW | Per-slave register contents |
| m2s_valid_i | input | 1 | Master write to slave 0 |
| m2s_data_i | input | DW | Master write data |
| s2m_data_o | output | DW | Slave 0 register for the master |
| coord_x_o | output | N*XW | Column of each slave |
| coord_y_o | output | N*YW | Row of each slave |

## Verification
The collision of interest is a shift landing in the same cycle as a write, whether a slave put, an M2S, or both aimed at slave 0. A pseudo-random sweep drives shift direction, per-slave put strobes and M2S together on a 4x2 grid, so these overlaps occur often, alongside directed cases. After each edge the bench compares every register with a model that applies the rotation first and the writes second. It also checks that slave 0 takes the master's data when a put by slave 0 collides with an M2S.

// File: rtl/grid_net_pkg.sv
package grid_net_pkg;
  function automatic int unsigned w_of(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
  function automatic int unsigned col_of(input int unsigned s, input int unsigned cols);
    return s % cols;
  endfunction
  function automatic int unsigned row_of(input int unsigned s, input int unsigned cols);
    return s / cols;
  endfunction
  function automatic int unsigned left_src(input int unsigned s, input int unsigned cols);
    return row_of(s, cols) * cols + (col_of(s, cols) + 1) % cols;
  endfunction
  function automatic int unsigned right_src(input int unsigned s, input int unsigned cols);
    return row_of(s, cols) * cols + (col_of(s, cols) + cols - 1) % cols;
  endfunction
endpackage

// File: rtl/grid_net_cell.sv
module grid_net_cell #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_en_i,
  input  logic [DW-1:0] shift_src_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] q_d;

  // shift first, write lands on top
  always_comb begin
    q_d = q_o;
    if (shift_en_i) q_d = shift_src_i;
    if (wr_en_i)    q_d = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> q_o == $past(wr_data_i)); // R8
  AST_SHIFT_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en_i && !wr_en_i) |=> q_o == $past(shift_src_i)); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_en_i && !wr_en_i) |=> $stable(q_o)); // R10
endmodule

// File: rtl/grid_net_coord.sv
module grid_net_coord #(
  parameter int unsigned IDX  = 0,
  parameter int unsigned COLS = 4,
  parameter int unsigned XW   = 2,
  parameter int unsigned YW   = 1
) (
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o
);
  import grid_net_pkg::*;
  localparam int unsigned X = col_of(IDX, COLS);
  localparam int unsigned Y = row_of(IDX, COLS);
  assign x_o = XW'(X);
  assign y_o = YW'(Y);
endmodule

// File: rtl/grid_net.sv
module grid_net #(
  parameter int unsigned COLS = 4,
  parameter int unsigned ROWS = 2,
  parameter int unsigned DW   = 8,
  localparam int unsigned N   = COLS * ROWS,
  localparam int unsigned XW  = grid_net_pkg::w_of(COLS),
  localparam int unsigned YW  = grid_net_pkg::w_of(ROWS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            shift_left_i,
  input  logic            shift_right_i,
  input  logic [N-1:0]    put_valid_i,
  input  logic [N*DW-1:0] put_data_i,
  output logic [N*DW-1:0] get_data_o,
  input  logic            m2s_valid_i,
  input  logic [DW-1:0]   m2s_data_i,
  output logic [DW-1:0]   s2m_data_o,
  output logic [N*XW-1:0] coord_x_o,
  output logic [N*YW-1:0] coord_y_o
);
  import grid_net_pkg::*;

  localparam int unsigned L0 = left_src(0, COLS);
  localparam int unsigned R0 = right_src(0, COLS);

  logic [DW-1:0] q [N];
  logic          shift_en;

  assign shift_en = shift_left_i ^ shift_right_i;  // both high cancels

  for (genvar s = 0; s < N; s++) begin : g_slave
    localparam int unsigned LS = left_src(s, COLS);
    localparam int unsigned RS = right_src(s, COLS);
    logic [DW-1:0] src;
    logic          wr_en;
    logic [DW-1:0] wr_data;

    assign src = shift_left_i ? q[LS] : q[RS];

    if (s == 0) begin : g_master_port
      assign wr_en   = put_valid_i[s] | m2s_valid_i;
      assign wr_data = m2s_valid_i ? m2s_data_i : put_data_i[s*DW +: DW];
    end else begin : g_plain
      assign wr_en   = put_valid_i[s];
      assign wr_data = put_data_i[s*DW +: DW];
    end

    grid_net_cell #(.DW(DW)) u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .shift_en_i (shift_en),
      .shift_src_i(src),
      .wr_en_i    (wr_en),
      .wr_data_i  (wr_data),
      .q_o        (q[s])
    );

    grid_net_coord #(.IDX(s), .COLS(COLS), .XW(XW), .YW(YW)) u_coord (
      .x_o(coord_x_o[s*XW +: XW]),
      .y_o(coord_y_o[s*YW +: YW])
    );

    assign get_data_o[s*DW +: DW] = q[s];
  end

  assign s2m_data_o = q[0];

  AST_M2S_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m2s_valid_i |=> s2m_data_o == $past(m2s_data_i)); // R4
  AST_ROT_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_left_i && !shift_right_i && !m2s_valid_i && !put_valid_i[0])
      |=> s2m_data_o == $past(q[L0])); // R5
  AST_ROT_RIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_right_i && !shift_left_i && !m2s_valid_i && !put_valid_i[0])
      |=> s2m_data_o == $past(q[R0])); // R6
  AST_BOTH_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_right_i && shift_left_i && !m2s_valid_i && !put_valid_i[0])
      |=> $stable(s2m_data_o)); // R7
endmodule

// File: tb/grid_net_test.sv
module grid_net_test;
  localparam int COLS = 4, ROWS = 2, DW = 8, N = COLS * ROWS, XW = 2, YW = 1;

  logic clk = 0, rst_n = 0;
  logic sl = 0, sr = 0, mv = 0;
  logic [N-1:0] pv = '0;
  logic [N*DW-1:0] pd = '0;
  logic [DW-1:0] md = '0;
  logic [N*DW-1:0] gd;
  logic [DW-1:0] s2m;
  logic [N*XW-1:0] cx;
  logic [N*YW-1:0] cy;

  int errors = 0, checks = 0;
  logic [DW-1:0] model [N];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;  // 50 MHz

  grid_net #(.COLS(COLS), .ROWS(ROWS), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .shift_left_i(sl), .shift_right_i(sr),
    .put_valid_i(pv), .put_data_i(pd), .get_data_o(gd),
    .m2s_valid_i(mv), .m2s_data_i(md), .s2m_data_o(s2m),
    .coord_x_o(cx), .coord_y_o(cy));

  task automatic compare(input string req);
    logic [DW-1:0] n;
    for (int s = 0; s < N; s++) begin
      checks++;
      n = gd[s*DW +: DW];
      if (n !== model[s]) begin
        errors++;
        $display("FAIL %s slave %0d: got %h exp %h", req, s, n, model[s]);
      end
    end
    checks++;
    if (s2m !== model[0]) begin
      errors++;
      $display("FAIL R3 s2m: got %h exp %h", s2m, model[0]);
    end
  endtask

  // drive one cycle, update model: rotate first, then writes, M2S last
  task automatic step(input logic l, input logic r, input logic [N-1:0] v,
                      input logic [N*DW-1:0] d, input logic m, input logic [DW-1:0] mdat,
                      input string req);
    logic [DW-1:0] nx [N];
    @(negedge clk);
    sl = l; sr = r; pv = v; pd = d; mv = m; md = mdat;
    for (int s = 0; s < N; s++) begin
      int x, y;
      x = s % COLS; y = s / COLS;
      if (l && !r)      nx[s] = model[y*COLS + (x+1) % COLS];
      else if (r && !l) nx[s] = model[y*COLS + (x+COLS-1) % COLS];
      else              nx[s] = model[s];
    end
    for (int s = 0; s < N; s++) if (v[s]) nx[s] = d[s*DW +: DW];
    if (m) nx[0] = mdat;
    for (int s = 0; s < N; s++) model[s] = nx[s];
    @(posedge clk); #1;
    compare(req);
  endtask

  function automatic logic [N*DW-1:0] pattern(input int base);
    logic [N*DW-1:0] p;
    for (int s = 0; s < N; s++) p[s*DW +: DW] = DW'(base + s * 17 + 1);
    return p;
  endfunction

  initial begin
    #200_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int s = 0; s < N; s++) model[s] = '0;
    #35; compare("R1");
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1; compare("R1");

    // R9 coordinates
    for (int s = 0; s < N; s++) begin
      checks++;
      if (cx[s*XW +: XW] !== XW'(s % COLS) || cy[s*YW +: YW] !== YW'(s / COLS)) begin
        errors++;
        $display("FAIL R9 slave %0d: got %0d,%0d exp %0d,%0d", s,
                 cx[s*XW +: XW], cy[s*YW +: YW], s % COLS, s / COLS);
      end
    end

    step(0, 0, '1, pattern(0), 0, '0, "R2");
    step(0, 0, '0, '0, 0, '0, "R10");
    // R5: master walks row 0 by left shifts
    for (int k = 0; k < COLS; k++) begin
      checks++;
      if (s2m !== DW'((k % COLS) * 17 + 1)) begin
        errors++;
        $display("FAIL R5 walk %0d: got %h exp %h", k, s2m, DW'((k % COLS) * 17 + 1));
      end
      step(1, 0, '0, '0, 0, '0, "R5");
    end
    for (int k = 0; k < COLS + 1; k++) step(0, 1, '0, '0, 0, '0, "R6");
    step(1, 1, '0, '0, 0, '0, "R7");
    step(0, 0, 8'h01, pattern(40), 1, 8'h5A, "R4");
    step(1, 0, 8'h81, pattern(80), 0, '0, "R8");
    step(0, 1, 8'h01, pattern(90), 1, 8'hC3, "R8");

    // pseudo-random collisions of shifts, puts and M2S
    for (int i = 0; i < 600; i++) begin
      logic [N*DW-1:0] d;
      for (int s = 0; s < N; s++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        d[s*DW +: DW] = lfsr[DW-1:0];
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[1], lfsr[9:2] & lfsr[15:8], d, lfsr[3] & lfsr[7],
           lfsr[DW-1:0] ^ 8'h3C, "R8");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule